// File: doc/BRIEF.md
# Supervisory Reset Delay Timer

This block sits behind a supply comparator and turns its raw "supply above threshold" flag into two outputs: a supply-good output that tracks the flag with no delay, and an active-low system reset whose edges are deliberately delayed and asymmetric. Reset is released only once the supply has stayed good for a long, continuous interval. It is asserted only after the supply has stayed bad for a short interval. Because supply-good leads reset on the way down, a processor can take supply-good as an early warning and run a short shutdown routine before reset lands.

A set of immediate reset requests skips the delay. These requests are: either connector-sense input reporting a removed board, a hard-reset request, undervoltage lockout on either rail, and a latched overcurrent fault. Any one of them pulls reset low on the next clock. All delays come from a single run-length counter. The counter restarts whenever the flag changes, and it is held at zero while any request is active. Both delays are parameters in clock cycles.

Top module: `supply_reset_timer`

## Requirements
- R1: `supply_good` equals `cmp_above` in the same cycle, in both directions, with no clock delay.
- R2: `sys_rst_n` is low while `rst_n` is low and stays low on the first clock edge after `rst_n` rises.
- R3: With no request active, `sys_rst_n` goes high right after the clock edge at which `cmp_above` has been sampled high on RELEASE_CYCLES consecutive edges.
- R4: A high run of `cmp_above` shorter than RELEASE_CYCLES samples leaves `sys_rst_n` low.
- R5: With no request active, `sys_rst_n` goes low right after the clock edge at which `cmp_above` has been sampled low on ASSERT_CYCLES consecutive edges.
- R6: A low dip of `cmp_above` shorter than ASSERT_CYCLES samples leaves `sys_rst_n` high.
- R7: If any request input is high when a clock edge samples it, `sys_rst_n` is low after that edge, whatever the value of `cmp_above`.
- R8: While any request is active, the run count is cleared. Once all requests are clear, release again needs RELEASE_CYCLES consecutive high samples, counted from the first edge with no request.
- R9: Each request input acts alone as in R7. All request inputs are active high: `con_a` and `con_b` (high means the board is not connected), `hard_req`, `uvlo_lo`, `uvlo_hi`, `oc_fault`.
- R10: The run count restarts on every change of `cmp_above`, so high or low runs separated by a change never add together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_above | input | 1 | Comparator flag, high when the supply is above threshold |
| con_a | input | 1 | Connector sense A, high when the board is not connected |
| con_b | input | 1 | Connector sense B, high when the board is not connected |
| hard_req | input | 1 | Hard-reset request, active high |
| uvlo_lo | input | 1 | Undervoltage lockout on the low rail |
| uvlo_hi | input | 1 | Undervoltage lockout on the high rail |
| oc_fault | input | 1 | Latched overcurrent fault |
| supply_good | output | 1 | Supply-good output, follows the comparator flag |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Some properties are checked by assertions on every cycle:
- Any request forces reset low on the next edge.
- A request clears the run count.
- A flag change restarts the count at one.
- A rising reset is always preceded by a registered good flag and no request.
- A falling reset that no request caused is always preceded by a registered bad flag.

Other properties need the bench's scenarios, because they depend on exact run lengths:
- Release happens at exactly the RELEASE_CYCLES-th sample.
- Assertion happens at exactly the ASSERT_CYCLES-th sample.
- A pulse or dip one sample short has no effect on reset.
- Alternating runs never add together.
- Each request input acts on its own.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef struct packed {
    logic con_a;
    logic con_b;
    logic hard;
    logic uvlo_lo;
    logic uvlo_hi;
    logic oc;
  } req_vec_t;

  typedef enum logic [1:0] {
    ACT_KEEP    = 2'd0,
    ACT_RELEASE = 2'd1,
    ACT_ASSERT  = 2'd2
  } rst_act_e;

  localparam int unsigned REQ_N = $bits(req_vec_t);

endpackage

// File: rtl/srt_req_merge.sv
module srt_req_merge
  import srt_pkg::*;
(
  input  req_vec_t req,
  output logic     any_req
);

  logic [REQ_N-1:0] req_bits;
  logic [REQ_N:0]   chain;

  assign req_bits = req;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < REQ_N; i++) begin : g_or
    assign chain[i+1] = chain[i] | req_bits[i];
  end

  assign any_req = chain[REQ_N];

endmodule

// File: rtl/srt_run_counter.sv
module srt_run_counter #(
  parameter int unsigned RUN_MAX = 1000,
  parameter int unsigned W       = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  input  logic         hold,
  output logic         good_q,
  output logic [W-1:0] run_len,
  output logic [W-1:0] run_next
);

  localparam logic [W-1:0] RUN_MAX_W = W'(RUN_MAX);
  localparam logic [W-1:0] ONE_W     = W'(1);

  function automatic logic [W-1:0] run_step(input logic [W-1:0] cur,
                                            input logic         restart);
    if (restart)            return ONE_W;
    else if (cur >= RUN_MAX_W) return cur;
    else                    return cur + ONE_W;
  endfunction

  logic level_changed;

  assign level_changed = (level != good_q);
  assign run_next      = hold ? '0 : run_step(run_len, level_changed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_q  <= 1'b0;
      run_len <= '0;
    end else begin
      good_q  <= level;
      run_len <= run_next;
    end
  end

  // R8
  hold_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (run_len == '0));

  // R10
  change_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && level_changed) |=> (run_len == ONE_W));

  // R3
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_MAX_W);

endmodule

// File: rtl/srt_out_stage.sv
module srt_out_stage
  import srt_pkg::*;
#(
  parameter int unsigned RELEASE_CYCLES = 1000,
  parameter int unsigned ASSERT_CYCLES  = 10,
  parameter int unsigned W              = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  input  logic         any_req,
  input  logic [W-1:0] run_next,
  output logic         rst_out
);

  localparam logic [W-1:0] REL_W = W'(RELEASE_CYCLES);
  localparam logic [W-1:0] ASR_W = W'(ASSERT_CYCLES);

  function automatic rst_act_e pick_action(input logic         req,
                                           input logic         lvl,
                                           input logic [W-1:0] run);
    if (req)                     return ACT_ASSERT;
    else if (lvl && run >= REL_W)  return ACT_RELEASE;
    else if (!lvl && run >= ASR_W) return ACT_ASSERT;
    else                         return ACT_KEEP;
  endfunction

  rst_act_e act;

  assign act = pick_action(any_req, level, run_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_out <= 1'b0;
    end else begin
      case (act)
        ACT_RELEASE: rst_out <= 1'b1;
        ACT_ASSERT:  rst_out <= 1'b0;
        default:     rst_out <= rst_out;
      endcase
    end
  end

  // R7
  req_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !rst_out);

endmodule

// File: rtl/supply_reset_timer.sv
module supply_reset_timer
  import srt_pkg::*;
#(
  parameter int unsigned RELEASE_CYCLES = 40_000_000,
  parameter int unsigned ASSERT_CYCLES  = 6_400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_above,
  input  logic con_a,
  input  logic con_b,
  input  logic hard_req,
  input  logic uvlo_lo,
  input  logic uvlo_hi,
  input  logic oc_fault,
  output logic supply_good,
  output logic sys_rst_n
);

  localparam int unsigned RUN_W = $clog2(RELEASE_CYCLES + 1);

  req_vec_t           req;
  logic               any_req;
  logic               sup_good_q;
  logic [RUN_W-1:0]   run_len;
  logic [RUN_W-1:0]   run_next;

  assign req = '{con_a: con_a, con_b: con_b, hard: hard_req,
                 uvlo_lo: uvlo_lo, uvlo_hi: uvlo_hi, oc: oc_fault};

  assign supply_good = cmp_above;

  srt_req_merge u_merge (
    .req     (req),
    .any_req (any_req)
  );

  srt_run_counter #(
    .RUN_MAX (RELEASE_CYCLES),
    .W       (RUN_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (cmp_above),
    .hold     (any_req),
    .good_q   (sup_good_q),
    .run_len  (run_len),
    .run_next (run_next)
  );

  srt_out_stage #(
    .RELEASE_CYCLES (RELEASE_CYCLES),
    .ASSERT_CYCLES  (ASSERT_CYCLES),
    .W              (RUN_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (cmp_above),
    .any_req  (any_req),
    .run_next (run_next),
    .rst_out  (sys_rst_n)
  );

  initial begin
    // R5
    delay_order_chk: assert (RELEASE_CYCLES > ASSERT_CYCLES && ASSERT_CYCLES > 0);
  end

  // R3
  release_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (sup_good_q && !$past(any_req)));

  // R5
  assert_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_rst_n) && !$past(any_req)) |-> !sup_good_q);

endmodule

// File: tb/supply_reset_timer_bench.sv
`timescale 1ns/1ps
module supply_reset_timer_bench;

  localparam int REL = 40;
  localparam int ASR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_above = 1'b1;
  logic con_a = 1'b0, con_b = 1'b0, hard_req = 1'b0;
  logic uvlo_lo = 1'b0, uvlo_hi = 1'b0, oc_fault = 1'b0;
  logic supply_good, sys_rst_n;

  int tests = 0;
  int fails = 0;
  string cur_req = "R2";
  bit done = 1'b0;

  // model state
  int  hi_run = 0;
  int  lo_run = 0;
  logic m_rst_n = 1'b0;

  always #2.5 clk = ~clk;

  supply_reset_timer #(.RELEASE_CYCLES(REL), .ASSERT_CYCLES(ASR)) u_supply_reset_timer (
    .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above),
    .con_a(con_a), .con_b(con_b), .hard_req(hard_req),
    .uvlo_lo(uvlo_lo), .uvlo_hi(uvlo_hi), .oc_fault(oc_fault),
    .supply_good(supply_good), .sys_rst_n(sys_rst_n)
  );

  // behavioural reference: run lengths as plain integers
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst_n = 1'b0; hi_run = 0; lo_run = 0;
    end else if (con_a || con_b || hard_req || uvlo_lo || uvlo_hi || oc_fault) begin
      m_rst_n = 1'b0; hi_run = 0; lo_run = 0;
    end else if (cmp_above) begin
      hi_run++; lo_run = 0;
      if (hi_run >= REL) m_rst_n = 1'b1;
    end else begin
      lo_run++; hi_run = 0;
      if (lo_run >= ASR) m_rst_n = 1'b0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check({cur_req, " model"}, sys_rst_n, m_rst_n);
      check("R1 follow", supply_good, cmp_above);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic probe(input string tag, input logic exp);
    #1 check(tag, sys_rst_n, exp);
  endtask

  task automatic release_from_low(input string tag);
    step(REL - 1); probe(tag, 1'b0);
    step(1);       probe(tag, 1'b1);
  endtask

  task automatic pulse_req(input int which);
    case (which)
      0: con_a = 1'b1;
      1: con_b = 1'b1;
      2: hard_req = 1'b1;
      3: uvlo_lo = 1'b1;
      4: uvlo_hi = 1'b1;
      default: oc_fault = 1'b1;
    endcase
    step(1);
    probe("R9 single request", 1'b0);
    {con_a, con_b, hard_req, uvlo_lo, uvlo_hi, oc_fault} = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(3);
    probe("R2 in reset", 1'b0);
    rst_n = 1'b1;
    step(1);
    probe("R2 first edge", 1'b0);
    // R3: release on the REL-th consecutive high sample (one already counted)
    cur_req = "R3";
    step(REL - 2); probe("R3 one short", 1'b0);
    step(1);       probe("R3 release", 1'b1);

    // R5: assertion on the ASR-th low sample
    cur_req = "R5";
    cmp_above = 1'b0;
    #1 check("R1 immediate fall", supply_good, 1'b0);
    step(ASR - 1); probe("R5 one short", 1'b1);
    step(1);       probe("R5 assert", 1'b0);

    // R4 and R10: short high run, low, then a fresh full run
    cur_req = "R4";
    cmp_above = 1'b1;
    step(REL - 1); probe("R4 short pulse", 1'b0);
    cmp_above = 1'b0;
    step(3);
    cur_req = "R10";
    cmp_above = 1'b1;
    step(5);
    cmp_above = 1'b0;
    step(1);
    cmp_above = 1'b1;
    step(REL - 1); probe("R10 no accumulation", 1'b0);
    step(1);       probe("R10 fresh release", 1'b1);

    // R6 and R10: dips one short, separated by a single high sample
    cur_req = "R6";
    cmp_above = 1'b0;
    step(ASR - 1); probe("R6 dip", 1'b1);
    cmp_above = 1'b1;
    step(1);
    cmp_above = 1'b0;
    step(ASR - 1); probe("R10 dips not summed", 1'b1);
    cmp_above = 1'b1;
    step(2);       probe("R6 still released", 1'b1);

    // R7 and R9: each request alone, then R8 re-count
    for (int k = 0; k < 6; k++) begin
      cur_req = "R9";
      pulse_req(k);
      cur_req = "R8";
      release_from_low("R8 recount");
    end

    // R8: long request with supply good all along
    cur_req = "R8";
    hard_req = 1'b1;
    step(REL + 10); probe("R7 held request", 1'b0);
    hard_req = 1'b0;
    release_from_low("R8 after long request");

    // R7: request while supply low
    cur_req = "R7";
    cmp_above = 1'b0;
    oc_fault  = 1'b1;
    step(1); probe("R7 request with low flag", 1'b0);
    oc_fault  = 1'b0;
    step(3);
    cmp_above = 1'b1;
    release_from_low("R3 after request");
    step(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule